// File: doc/BRIEF.md
# Serial-Bus Clock-Enable Configuration Slave

This block is a slave on a two-wire serial bus that holds a small bank of configuration bytes whose bits gate a set of clock outputs. It runs from a fast system clock that oversamples the open-drain clock and data lines. The lines pass through a two-flop synchronizer and a short glitch filter. A bus engine finds start and stop conditions, matches the slave address and drives acknowledge bits. It shifts bytes in and out. The bits held in the bank appear in parallel on `clk_en_o` for downstream clock-gating logic.

A write carries two header bytes after the address: a command code and a byte count. Both are acknowledged and then dropped. Every byte after them lands in the bank in sequence, starting at byte 0. A read has no register pointer. The slave first sends the number of bank bytes and then the bank contents in sequence. The block has no stream interface and therefore no back-pressure. The only flow control is the bus acknowledge. Clock stretching is not used, so the host sets the pace.

Top module: `cfg_smbus_slave`

## Requirements
- R1: The slave acknowledges only the address bytes D2h (write) and D3h (read), which is 7-bit address 69h followed by the R/W bit. For any other address byte it leaves SDA released for the ack bit and for the rest of that transaction.
- R2: In a write, the first two bytes after the address are acknowledged and change no enable output, whatever their values.
- R3: Later write bytes are received MSB first, each is acknowledged, and they are stored into bank bytes 0, 1, 2 and so on, in that order.
- R4: A stop after any complete byte ends the write, and bank bytes not reached keep their previous values.
- R5: A read returns the byte count 7 first, then bank bytes 0 to 6 in order, MSB first. Any byte the host requests beyond byte 6 reads as FFh.
- R6: On reset all 13 enable outputs are 1.
- R7: Bank byte 0 bits 7..0 drive `clk_en_o[7:0]` and bank byte 1 bits 4..0 drive `clk_en_o[12:8]`. A 1 enables an output and a 0 holds it low.
- R8: Every bit that drives no output (byte 1 bits 7..5 and all of bytes 2 to 6) reads back as 1, whatever value was written to it.
- R9: Write bytes beyond bank byte 6 are acknowledged and discarded.
- R10: A start condition is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A repeated start restarts the byte sequence, so the next write again begins with the two header bytes and then byte 0.
- R11: If the host does not acknowledge a byte during a read, the slave releases SDA and does not drive it again until the next start.
- R12: An enable output changes only after all 8 bits of its byte have been received. A byte cut short by a stop changes nothing.
- R13: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as sensed at the pad |
| sda_i | input | 1 | Bus data line as sensed at the pad |
| sda_drive_low_o | output | 1 | 1 pulls the data line low; 0 releases it |
| clk_en_o | output | 13 | Per-output clock enable, 1 = running |

## Verification
The assertions assume a well-behaved host. It changes SDA only while SCL is low, except when it forms a start or a stop. Every SCL phase lasts longer than the synchronizer and filter latency. The host never tries a start or stop while the slave is pulling SDA low. The bench host keeps to these rules: each half bit lasts 40 system clocks, and data changes only at the midpoint of the low phase. It also makes sure that a stop or a repeated start follows only a bit that the host itself drove or left released.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRX,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_WAIT
  } bus_st_t;
endpackage

// File: rtl/smbcfg_sync_filt.sv
module smbcfg_sync_filt #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  // two-flop synchronizer, then require FILT_LEN agreeing samples
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      clean  <= 1'b1;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (sync_q[1] == clean) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        clean <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R10: the filtered level only moves toward what the synchronizer saw
  a_r10_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clean) |-> (clean == $past(sync_q[1])));
endmodule

// File: rtl/smbcfg_regs.sv
module smbcfg_regs #(
  parameter int NUM_EN    = 13,
  parameter int NUM_BYTES = 7,
  parameter int IW        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [7:0]        rd_data,
  output logic [NUM_EN-1:0] en_o
);
  logic [NUM_EN-1:0] en_q;
  logic [7:0]        img_b [NUM_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '1;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_EN; i++) begin
        if (wr_idx == IW'(i / 8)) en_q[i] <= wr_data[i[2:0]];
      end
    end
  end

  // bits without an output read as 1
  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
    for (genvar b = 0; b < 8; b++) begin : g_bit
      localparam int IDX = k * 8 + b;
      if (IDX < NUM_EN) begin : g_live
        assign img_b[k][b] = en_q[IDX];
      end else begin : g_rsvd
        assign img_b[k][b] = 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (rd_idx == IW'(k)) rd_data = img_b[k];
    end
  end

  assign en_o = en_q;

  // R6: reset loads every enable as 1
  a_r6_reset_all_on: assert property (@(posedge clk)
    !rst_n |=> (en_q == '1));
  // R12: the enables move only on a whole-byte commit
  a_r12_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/smbcfg_bus_fsm.sv
module smbcfg_bus_fsm
  import smbcfg_pkg::*;
#(
  parameter logic [6:0] ADDR7     = 7'h69,
  parameter int         NUM_BYTES = 7,
  parameter int         IW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic [IW-1:0] rd_idx
);
  bus_st_t       st;
  logic          scl_q, sda_q;
  logic [2:0]    bit_cnt;
  logic [7:0]    sh, tx_sh;
  logic          full, rw, ack_ok;
  logic [IW-1:0] cnt;

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_ev = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_ev  = scl_f & scl_q & ~sda_q & sda_f;

  function automatic logic [IW-1:0] sat_inc(input logic [IW-1:0] v);
    return (v == {IW{1'b1}}) ? v : v + 1'b1;
  endfunction

  // cnt == 0 means the count byte goes out next
  wire [7:0] tx_next = (cnt == '0) ? 8'(NUM_BYTES) : rd_data;
  wire       in_bank = (cnt >= IW'(2)) && ((cnt - IW'(2)) < IW'(NUM_BYTES));

  assign rd_idx = cnt - 1'b1;
  assign sda_oe = (st == ST_ACK) | ((st == ST_TX) & ~tx_sh[7]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      bit_cnt <= '0;
      sh      <= '0;
      tx_sh   <= 8'hFF;
      full    <= 1'b0;
      rw      <= 1'b0;
      ack_ok  <= 1'b0;
      cnt     <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      wr_en <= 1'b0;
      if (stop_ev) begin
        st <= ST_IDLE;
      end else if (start_ev) begin
        st      <= ST_ADDR;
        bit_cnt <= '0;
        full    <= 1'b0;
        cnt     <= '0;
      end else begin
        unique case (st)
          ST_ADDR, ST_WRX: begin
            if (scl_rise) begin
              sh      <= {sh[6:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == 3'd7) full <= 1'b1;
            end else if (scl_fall && full) begin
              full <= 1'b0;
              if (st == ST_ADDR) begin
                if (sh[7:1] == ADDR7) begin
                  rw <= sh[0];
                  st <= ST_ACK;
                end else begin
                  st <= ST_WAIT;
                end
              end else begin
                st <= ST_ACK;
                if (in_bank) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= cnt - IW'(2);
                  wr_data <= sh;
                end
                cnt <= sat_inc(cnt);
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw) begin
                st    <= ST_TX;
                tx_sh <= tx_next;
                cnt   <= sat_inc(cnt);
              end else begin
                st <= ST_WRX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              tx_sh   <= {tx_sh[6:0], 1'b1};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == 3'd7) st <= ST_RACK;
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              ack_ok <= ~sda_f;
            end else if (scl_fall) begin
              if (ack_ok) begin
                st      <= ST_TX;
                tx_sh   <= tx_next;
                cnt     <= sat_inc(cnt);
                bit_cnt <= '0;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R13: drive only moves while the clock line is low
  a_r13_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q)) |-> $stable(sda_oe));
  // R1: a foreign address is never acknowledged
  a_r1_no_ack_foreign: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR && scl_fall && full && sh[7:1] != ADDR7) |=> !sda_oe);
  // R2: header bytes never reach the bank
  a_r2_header_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WRX && scl_fall && full && cnt < IW'(2)) |=> !wr_en);
  // R11: missing host ack leaves the line released
  a_r11_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RACK && scl_fall && !ack_ok) |=> (st == ST_WAIT && !sda_oe));
endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave #(
  parameter logic [6:0] ADDR7     = 7'h69,
  parameter int         NUM_EN    = 13,
  parameter int         NUM_BYTES = 7,
  parameter int         FILT_LEN  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_low_o,
  output logic [NUM_EN-1:0] clk_en_o
);
  localparam int IW = $clog2(NUM_BYTES + 3);

  logic          scl_f, sda_f;
  logic          wr_en;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [7:0]    wr_data, rd_data;

  smbcfg_sync_filt #(.FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .raw(scl_i), .clean(scl_f));

  smbcfg_sync_filt #(.FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .raw(sda_i), .clean(sda_f));

  smbcfg_bus_fsm #(.ADDR7(ADDR7), .NUM_BYTES(NUM_BYTES), .IW(IW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .rd_data(rd_data), .sda_oe(sda_drive_low_o), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx));

  smbcfg_regs #(.NUM_EN(NUM_EN), .NUM_BYTES(NUM_BYTES), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .en_o(clk_en_o));
endmodule

// File: tb/cfg_smbus_slave_tb_top.sv
module cfg_smbus_slave_tb_top;
  localparam int Q  = 20;
  localparam int HP = 2 * Q;

  typedef struct packed {
    logic [7:0]  b0;
    logic [7:0]  b1;
    logic [12:0] exp;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'h00, 8'h00, 13'h0000},
    '{8'hA5, 8'h3C, 13'h1CA5},
    '{8'h5A, 8'hC3, 13'h035A},
    '{8'hFF, 8'hFF, 13'h1FFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        host_pull = 1'b0;
  logic        sda_oe;
  logic [12:0] en;
  logic        sda_line;
  int          total = 0;
  int          bad = 0;
  int          r13_viol = 0;
  logic        prev_scl = 1'b1;
  logic        prev_oe = 1'b0;

  always #5 clk = ~clk;
  assign sda_line = ~(host_pull | sda_oe);

  cfg_smbus_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_drive_low_o(sda_oe), .clk_en_o(en));

  always @(negedge clk) begin
    if (rst_n && scl && prev_scl && sda_oe !== prev_oe) r13_viol++;
    prev_scl = scl;
    prev_oe  = sda_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    tick(Q); host_pull = 1'b1; tick(Q); scl = 1'b0;
  endtask

  task automatic bus_rstart();
    tick(Q); host_pull = 1'b0; tick(Q); scl = 1'b1;
    tick(Q); host_pull = 1'b1; tick(Q); scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); host_pull = 1'b1; tick(Q); scl = 1'b1;
    tick(Q); host_pull = 1'b0; tick(HP);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      tick(Q); host_pull = ~b[i]; tick(Q); scl = 1'b1; tick(HP); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    tick(Q); host_pull = 1'b0; tick(Q); scl = 1'b1;
    tick(Q); ack = ~sda_line; tick(Q); scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic host_ack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); host_pull = 1'b0; tick(Q); scl = 1'b1;
      tick(Q); b[i] = sda_line; tick(Q); scl = 1'b0;
    end
    tick(Q); host_pull = host_ack; tick(Q); scl = 1'b1; tick(HP); scl = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic       ack;
    logic [7:0] rb;
    tick(6);
    check("R6 enables during reset", 32'(en), 32'h1FFF);
    rst_n = 1'b1;
    tick(10);
    check("R6 enables after reset", 32'(en), 32'h1FFF);
    check("R1 idle line released", 32'(sda_oe), 32'h0);

    // table-driven two-byte writes
    for (int v = 0; v < 4; v++) begin
      bus_start();
      send_byte(8'hD2, ack); check("R1 write address ack", 32'(ack), 32'h1);
      send_byte(8'h00, ack); check("R2 command ack", 32'(ack), 32'h1);
      send_byte(8'h00, ack); check("R2 count ack", 32'(ack), 32'h1);
      send_byte(VECS[v].b0, ack); check("R3 byte0 ack", 32'(ack), 32'h1);
      send_byte(VECS[v].b1, ack); check("R3 byte1 ack", 32'(ack), 32'h1);
      bus_stop(); tick(20);
      check("R7 enable map", 32'(en), 32'(VECS[v].exp));
    end

    // load A5/3C and read the whole bank back
    bus_start();
    send_byte(8'hD2, ack); send_byte(8'h11, ack); send_byte(8'h22, ack);
    send_byte(8'hA5, ack); send_byte(8'h3C, ack);
    bus_stop(); tick(20);
    check("R3 header values ignored", 32'(en), 32'h1CA5);
    bus_start();
    send_byte(8'hD3, ack); check("R1 read address ack", 32'(ack), 32'h1);
    recv_byte(rb, 1'b1); check("R5 byte count", 32'(rb), 32'h07);
    recv_byte(rb, 1'b1); check("R5 byte0 readback", 32'(rb), 32'hA5);
    recv_byte(rb, 1'b1); check("R8 byte1 reserved bits", 32'(rb), 32'hFC);
    for (int k = 2; k < 7; k++) begin
      recv_byte(rb, 1'b1); check("R8 reserved byte", 32'(rb), 32'hFF);
    end
    recv_byte(rb, 1'b0); check("R5 past last byte", 32'(rb), 32'hFF);
    bus_stop(); tick(20);
    check("R5 read leaves enables", 32'(en), 32'h1CA5);

    // header only
    bus_start();
    send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
    bus_stop(); tick(20);
    check("R2 header-only write", 32'(en), 32'h1CA5);

    // stop after byte 0
    bus_start();
    send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
    send_byte(8'h0F, ack);
    bus_stop(); tick(20);
    check("R4 early stop", 32'(en), 32'h1C0F);

    // byte 1 cut after four bits
    bus_start();
    send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
    send_byte(8'hF0, ack);
    send_bits(8'h00, 4);
    bus_stop(); tick(20);
    check("R12 partial byte", 32'(en), 32'h1CF0);

    // overlong write
    bus_start();
    send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
    send_byte(8'h33, ack); send_byte(8'h0A, ack);
    for (int k = 0; k < 7; k++) begin
      send_byte(8'h00, ack); check("R9 extra byte ack", 32'(ack), 32'h1);
    end
    bus_stop(); tick(20);
    check("R9 extra bytes dropped", 32'(en), 32'h0A33);

    // repeated start restarts the sequence
    bus_start();
    send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
    send_byte(8'h44, ack); send_byte(8'h15, ack);
    bus_rstart();
    send_byte(8'hD2, ack); check("R10 address after restart", 32'(ack), 32'h1);
    send_byte(8'h00, ack); send_byte(8'h00, ack);
    send_byte(8'h66, ack);
    bus_stop(); tick(20);
    check("R10 sequence restart", 32'(en), 32'h1566);

    // foreign addresses
    bus_start();
    send_byte(8'hA4, ack); check("R1 foreign address nack", 32'(ack), 32'h0);
    send_byte(8'h00, ack); check("R1 silent after mismatch", 32'(ack), 32'h0);
    bus_stop();
    bus_start();
    send_byte(8'hD0, ack); check("R1 near address nack", 32'(ack), 32'h0);
    bus_stop(); tick(20);
    check("R1 enables untouched", 32'(en), 32'h1566);

    // host nack during read
    bus_start();
    send_byte(8'hD3, ack);
    recv_byte(rb, 1'b1);
    recv_byte(rb, 1'b0); check("R11 byte before nack", 32'(rb), 32'h66);
    recv_byte(rb, 1'b0); check("R11 line released", 32'(rb), 32'hFF);
    bus_stop();
    bus_start();
    send_byte(8'hD3, ack); check("R11 new read acked", 32'(ack), 32'h1);
    recv_byte(rb, 1'b0); check("R5 count on new read", 32'(rb), 32'h07);
    bus_stop(); tick(20);

    check("R13 drive changes with clock high", 32'(r13_viol), 32'h0);
    summary();
  end
endmodule